// File: doc/BRIEF.md
# Clock controller register bank

This block is the software-visible register bank of a clock control unit. It decodes a 4 KiB window on a simple word-wide bus into 27 word slots. Each slot comes out of reset with its own fixed 32-bit constant. A small set of slots can be written, and each of those has its own write mask. The mode-control slot also forces a lock status bit high whenever it is written. Every other slot is read-only and keeps its reset constant.

A write to a read-only slot, or any access past the last slot, raises a one-cycle error pulse. Read data comes back from a register one cycle after the read request. Only full-word accesses are supported, so the two low address bits select nothing.

Top module: `ccu_regbank`

## Requirements
- R1: After reset, a read of each slot returns its constant: 0=0x074B0B7D, 1=0xFF870B48, 2=0x49FCFE7F, 3=0x007F0000, 4=0x04001800, 5=0x04051C03, 6=0x04043001, 7=0x00000280, 8 to 11=0xFFFFFFFF, 18=0x00004040, 23=0x80209828, 24=0x00AA0000, 25=0x00000285, and every other slot below 27 reads 0.
- R2: The slot index is addr[11:2]. addr[1:0] has no effect on which slot is read or written.
- R3: A write to slot 0 stores (wdata & 0x3B6FDFFF) | 0x04000000, so bit 26 always reads back as 1.
- R4: A write to slot 1 stores wdata & 0xFF9F3FFF.
- R5: A write to slot 4 or slot 6 stores wdata & 0xBFFF3FFF.
- R6: A write to slot 2, 8, 9 or 10 stores all 32 bits of wdata.
- R7: A write to any other index, including an index of 27 or more, changes no slot and raises err.
- R8: A read with index below 27 returns that slot on rdata in the cycle after rd_en and does not raise err. rdata holds its value in cycles with no read.
- R9: A read with index 27 or more returns 0 on rdata and raises err.
- R10: err is high for exactly the one cycle after a bad access, and low after a cycle with no bad access.
- R11: Driving rst_n low at any time returns every slot to its R1 constant. Reset is released synchronously, and a write that arrives while reset is held is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address within the window |
| wr_en | input | 1 | Write request for this cycle |
| rd_en | input | 1 | Read request for this cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle pulse after a bad access |

## Verification
The bench writes all ones and then all zeros to every writable slot. A design with a mask bit wrong, or without the forced bit 26 in slot 0, reads back a different word. It writes all ones to each read-only index and then reads the slot back. A design that lets such a write land, or that stays silent about it, shows up either as a changed value or as a missing error pulse. Reads at index 26, 27 and the top of the window catch an off-by-one range check, which would either return junk with no error or reject the last real slot. A reset in the middle of the run, and accesses with nonzero low address bits, catch a bank that does not reload its constants or that decodes the wrong address bits.

// File: rtl/ccu_regbank_pkg.sv
package ccu_regbank_pkg;

  localparam int WORD_W    = 32;
  localparam int WIN_AW    = 12;
  localparam int SLOT_CNT  = 27;

  // slot indices whose position is decoded by the clock logic
  localparam int SLOT_MODE     = 0;
  localparam int SLOT_DIV_MAIN = 1;
  localparam int SLOT_DIV_AUX  = 2;
  localparam int SLOT_PLL_CPU  = 4;
  localparam int SLOT_PLL_SER  = 6;
  localparam int SLOT_GATE0    = 8;
  localparam int SLOT_GATE1    = 9;
  localparam int SLOT_GATE2    = 10;

  localparam logic [WORD_W-1:0] MODE_LOCK_BIT = 32'h0400_0000;

  function automatic logic [WORD_W-1:0] slot_reset(input int i);
    case (i)
      0:             return 32'h074B_0B7D;
      1:             return 32'hFF87_0B48;
      2:             return 32'h49FC_FE7F;
      3:             return 32'h007F_0000;
      4:             return 32'h0400_1800;
      5:             return 32'h0405_1C03;
      6:             return 32'h0404_3001;
      7:             return 32'h0000_0280;
      8, 9, 10, 11:  return 32'hFFFF_FFFF;
      18:            return 32'h0000_4040;
      23:            return 32'h8020_9828;
      24:            return 32'h00AA_0000;
      25:            return 32'h0000_0285;
      default:       return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] slot_wmask(input int i);
    case (i)
      SLOT_MODE:                          return 32'h3B6F_DFFF;
      SLOT_DIV_MAIN:                      return 32'hFF9F_3FFF;
      SLOT_PLL_CPU, SLOT_PLL_SER:         return 32'hBFFF_3FFF;
      SLOT_DIV_AUX, SLOT_GATE0,
      SLOT_GATE1, SLOT_GATE2:             return 32'hFFFF_FFFF;
      default:                            return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] slot_force(input int i);
    return (i == SLOT_MODE) ? MODE_LOCK_BIT : '0;
  endfunction

endpackage

// File: rtl/ccu_rst_sync.sv
module ccu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ccu_addr_decode.sv
module ccu_addr_decode #(
  parameter int ADDR_W   = ccu_regbank_pkg::WIN_AW,
  parameter int NUM_REGS = ccu_regbank_pkg::SLOT_CNT
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                rd_en,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic                bad_access
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] writable;
  logic                unused_low;

  assign idx        = addr[ADDR_W-1:2];
  assign unused_low = ^addr[1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    assign hit[i]      = (idx == IDX_W'(i));
    assign writable[i] = (ccu_regbank_pkg::slot_wmask(i) != '0);
  end

  logic hit_any;
  logic hit_wr;

  always_comb begin
    hit_any    = |hit;
    hit_wr     = |(hit & writable);
    rd_sel     = hit;
    wr_sel     = wr_en ? (hit & writable) : '0;
    bad_access = (wr_en & ~hit_wr) | (rd_en & ~hit_any);
  end
endmodule

// File: rtl/ccu_reg_file.sv
module ccu_reg_file #(
  parameter int DATA_W   = ccu_regbank_pkg::WORD_W,
  parameter int NUM_REGS = ccu_regbank_pkg::SLOT_CNT
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_REGS-1:0]             wr_sel,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0] slots
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    localparam logic [DATA_W-1:0] RST_V  = DATA_W'(ccu_regbank_pkg::slot_reset(i));
    localparam logic [DATA_W-1:0] MASK_V = DATA_W'(ccu_regbank_pkg::slot_wmask(i));
    localparam logic [DATA_W-1:0] SET_V  = DATA_W'(ccu_regbank_pkg::slot_force(i));

    if (MASK_V != '0) begin : g_rw
      logic [DATA_W-1:0] val_q;
      logic [DATA_W-1:0] val_d;
      logic              val_en;

      always_comb begin
        val_en = wr_sel[i];
        val_d  = (wdata & MASK_V) | SET_V;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      val_q <= RST_V;
        else if (val_en) val_q <= val_d;
      end

      assign slots[i] = val_q;
    end else begin : g_ro
      assign slots[i] = RST_V;
    end
  end
endmodule

// File: rtl/ccu_read_port.sv
module ccu_read_port #(
  parameter int DATA_W   = ccu_regbank_pkg::WORD_W,
  parameter int NUM_REGS = ccu_regbank_pkg::SLOT_CNT
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en,
  input  logic [NUM_REGS-1:0]             rd_sel,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] slots,
  input  logic                            bad_access,
  output logic [DATA_W-1:0]               rdata,
  output logic                            err
);
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_sel[i]) rdata_d = rdata_d | slots[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= bad_access;
  end

  assign rdata = rdata_q;
  assign err   = err_q;
endmodule

// File: rtl/ccu_regbank.sv
module ccu_regbank #(
  parameter int DATA_W   = ccu_regbank_pkg::WORD_W,
  parameter int ADDR_W   = ccu_regbank_pkg::WIN_AW,
  parameter int NUM_REGS = ccu_regbank_pkg::SLOT_CNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  logic                            rst_n_sync;
  logic [NUM_REGS-1:0]             rd_sel;
  logic [NUM_REGS-1:0]             wr_sel;
  logic                            bad_access;
  logic [NUM_REGS-1:0][DATA_W-1:0] slots;

  ccu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ccu_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .wr_sel     (wr_sel),
    .bad_access (bad_access)
  );

  ccu_reg_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .wr_sel (wr_sel),
    .wdata  (wdata),
    .slots  (slots)
  );

  ccu_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .slots      (slots),
    .bad_access (bad_access),
    .rdata      (rdata),
    .err        (err)
  );
endmodule

// File: rtl/ccu_regbank_chk.sv
module ccu_regbank_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 27
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic              err
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] a_idx;
  logic             a_in_range;
  assign a_idx      = addr[ADDR_W-1:2];
  assign a_in_range = (a_idx < IDX_W'(NUM_REGS));

  // R10: an error pulse always follows some access
  assert_err_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    err |-> $past(wr_en || rd_en));

  // R3: slot 0 always shows its lock bit
  assert_lock_bit_set_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_en && a_idx == '0) |=> rdata[26]);

  // R9: reads past the last slot give zero and an error
  assert_oob_read_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_en && !a_in_range) |=> (rdata == '0 && err));

  // R8: good read with no write gives no error
  assert_good_read_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_en && !wr_en && a_in_range) |=> !err);

  // R7: a read-only slot keeps its constant
  assert_ro_slot_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_en && a_idx == IDX_W'(3)) |=> (rdata == 32'h007F_0000));

  // R8: rdata holds without a read
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !rd_en |=> $stable(rdata));
endmodule

bind ccu_regbank ccu_regbank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) chk_i (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .addr       (addr),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .rdata      (rdata),
  .err        (err)
);

// File: tb/ccu_regbank_tb_top.sv
module ccu_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] addr;
  logic        wr_en;
  logic        rd_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  ccu_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .err(err)
  );

  function automatic logic [31:0] exp_reset(input int i);
    case (i)
      0: return 32'h074B0B7D;  1: return 32'hFF870B48;
      2: return 32'h49FCFE7F;  3: return 32'h007F0000;
      4: return 32'h04001800;  5: return 32'h04051C03;
      6: return 32'h04043001;  7: return 32'h00000280;
      8, 9, 10, 11: return 32'hFFFFFFFF;
      18: return 32'h00004040; 23: return 32'h80209828;
      24: return 32'h00AA0000; 25: return 32'h00000285;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_mask(input int i);
    case (i)
      0: return 32'h3B6FDFFF;
      1: return 32'hFF9F3FFF;
      4, 6: return 32'hBFFF3FFF;
      2, 8, 9, 10: return 32'hFFFFFFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_store(input int i, input logic [31:0] d);
    return (d & exp_mask(i)) | ((i == 0) ? 32'h04000000 : 32'h0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, output logic e);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    e = err;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata; e = err;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_values();
    logic [31:0] d; logic e;
    check("R11 rdata after reset", rdata, 32'h0);
    check("R10 err after reset", {31'b0, err}, 32'h0);
    for (int i = 0; i < 27; i++) begin
      bus_read(12'(i * 4), d, e);
      check($sformatf("R1 slot %0d", i), d, exp_reset(i));
      check($sformatf("R8 no err slot %0d", i), {31'b0, e}, 32'h0);
    end
  endtask

  task automatic t_masked_writes();
    int idxs[8] = '{0, 1, 2, 4, 6, 8, 9, 10};
    logic [31:0] d; logic e;
    foreach (idxs[k]) begin
      int i = idxs[k];
      string tag = (i == 0) ? "R3" : (i == 1) ? "R4" : (i == 4 || i == 6) ? "R5" : "R6";
      bus_write(12'(i * 4), 32'hFFFFFFFF, e);
      check($sformatf("%s R7 no err write %0d", tag, i), {31'b0, e}, 32'h0);
      bus_read(12'(i * 4), d, e);
      check($sformatf("%s ones slot %0d", tag, i), d, exp_store(i, 32'hFFFFFFFF));
      bus_write(12'(i * 4), 32'h0, e);
      bus_read(12'(i * 4), d, e);
      check($sformatf("%s zeros slot %0d", tag, i), d, exp_store(i, 32'h0));
    end
  endtask

  task automatic t_readonly_writes();
    logic [31:0] d; logic e;
    for (int i = 0; i < 27; i++) begin
      if (exp_mask(i) == 32'h0) begin
        bus_write(12'(i * 4), 32'hFFFFFFFF, e);
        check($sformatf("R7 err on ro write %0d", i), {31'b0, e}, 32'h1);
        bus_read(12'(i * 4), d, e);
        check($sformatf("R7 ro slot %0d unchanged", i), d, exp_reset(i));
        check($sformatf("R10 err dropped %0d", i), {31'b0, e}, 32'h0);
      end
    end
    bus_write(12'd27 * 4, 32'h12345678, e);
    check("R7 err on oob write", {31'b0, e}, 32'h1);
  endtask

  task automatic t_out_of_range();
    logic [31:0] d; logic e;
    bus_read(12'd26 * 4, d, e);
    check("R8 last slot no err", {31'b0, e}, 32'h0);
    bus_read(12'd27 * 4, d, e);
    check("R9 idx 27 data", d, 32'h0);
    check("R9 idx 27 err", {31'b0, e}, 32'h1);
    bus_read(12'hFFC, d, e);
    check("R9 top data", d, 32'h0);
    check("R9 top err", {31'b0, e}, 32'h1);
    @(negedge clk);
    check("R10 err single cycle", {31'b0, err}, 32'h0);
    check("R8 rdata holds", rdata, 32'h0);
  endtask

  task automatic t_low_bits();
    logic [31:0] d; logic e;
    bus_write(12'h027, 32'hA5A5_5A5A, e);  // slot 9
    bus_read(12'h025, d, e);
    check("R2 low bits ignored", d, 32'hA5A5_5A5A);
    bus_read(12'h00F, d, e);               // slot 3
    check("R2 low bits read ro", d, exp_reset(3));
  endtask

  task automatic t_reset_mid();
    logic [31:0] d; logic e;
    bus_write(12'h004, 32'h0, e);
    addr = 12'h008; wdata = 32'h0; wr_en = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(12'h004, d, e);
    check("R11 slot1 reloaded", d, exp_reset(1));
    bus_read(12'h008, d, e);
    check("R11 write in reset lost", d, exp_reset(2));
    bus_read(12'h024, d, e);
    check("R11 slot9 reloaded", d, exp_reset(9));
  endtask

  initial begin
    addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    @(negedge clk);
    apply_reset();
    t_reset_values();
    t_masked_writes();
    t_readonly_writes();
    t_out_of_range();
    t_low_bits();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule